// File: doc/BRIEF.md
# Setpoint Request Priority Arbiter

This block picks the next system performance setpoint, one of sixteen, from the requests raised by several CPU-mode domains. A requester asks for a setpoint while running, on entry to sleep, or on wakeup. The union of all requested setpoints is narrowed twice. It is first masked by the row of an allowed-transition matrix that belongs to the setpoint now in force. It is then masked by the permitted-setpoint map of the CPU mode each active requester reports. Among the survivors, the setpoint with the largest programmable 4-bit priority wins.

The winner is published as the target, and a one-cycle start pulse goes to an external transition sequencer. When the sequencer returns its done pulse, the old current setpoint becomes the previous one and the target becomes current. While a transition is in flight, new requests are not sampled. A request that leaves no candidate raises a sticky flag for its kind (run, wakeup or sleep). Software clears these flags by writing ones.

A sleep request carries a second setpoint for the later wakeup. A per-request select can instead arrange that wakeup returns to whatever setpoint was current at the moment of sleep.

Top module: `setpoint_arbiter`

## Requirements
- R1: After reset, current, previous and target setpoint read 0, busy and start are low, and all three flags are clear.
- R2: The candidate set is the OR of the one-hot setpoints of all live requests, ANDed with the allowed-next row of the current setpoint (row for setpoint n at `allow_map_i[16n+15:16n]`) and with the mode row of every live requester (mode m at `mode_map_i[16m+15:16m]`, modes 0 run, 1 wait, 2 stop, 3 suspend).
- R3: Among the candidates the one with the numerically largest priority is taken; the priority of setpoint n sits in `prio_lo_i` for n<8 and in `prio_hi_i` for n≥8, at bits 4·(n mod 8)+3 down to 4·(n mod 8).
- R4: When candidates share the largest priority, the lowest setpoint index is taken.
- R5: A request with a non-empty candidate set, seen while idle, updates the target and raises `start_o` for exactly one cycle on the next clock; `busy_o` rises with it and stays high until done.
- R6: A done pulse while busy moves the old current value into previous and the target into current, and clears busy, on the next clock; a done pulse while idle changes nothing.
- R7: Requests seen while busy, and requests with kind code 3, are ignored: target, start and busy are unchanged.
- R8: A live request whose candidate set is empty starts nothing and sets the flag of every requesting kind on the next clock (kind codes 0 run, 1 sleep, 2 wakeup; flag bit 0 run, bit 1 wakeup, bit 2 sleep).
- R9: Writing 1 to a bit of `flag_clr_i` clears that flag; a flag set in the same cycle as its clear stays set; a flag without a clear holds.
- R10: A live sleep request stores a wakeup setpoint for its requester: the carried wakeup value when its select is 0, the current setpoint of that cycle when its select is 1; a later wakeup request from that requester asks for the stored value and ignores its own setpoint field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| allow_map_i | input | 256 | Allowed-next rows, 16 bits per setpoint |
| mode_map_i | input | 64 | Permitted setpoints, 16 bits per CPU mode |
| prio_lo_i | input | 32 | Priorities of setpoints 0..7 |
| prio_hi_i | input | 32 | Priorities of setpoints 8..15 |
| req_valid_i | input | 2 | Request strobe per requester |
| req_kind_i | input | 4 | Kind per requester, 2 bits each |
| req_sp_i | input | 8 | Requested setpoint per requester, 4 bits each |
| req_wake_sp_i | input | 8 | Wakeup setpoint carried by a sleep request, 4 bits each |
| req_wake_sel_i | input | 2 | Wakeup return select per requester |
| req_mode_i | input | 4 | CPU mode per requester, 2 bits each |
| done_i | input | 1 | Transition complete pulse from the sequencer |
| flag_clr_i | input | 3 | Write-1 clear of the not-allowed flags |
| target_o | output | 4 | Target setpoint |
| current_o | output | 4 | Current setpoint |
| previous_o | output | 4 | Previous setpoint |
| busy_o | output | 1 | Transition in flight |
| start_o | output | 1 | One-cycle transition start |
| flags_o | output | 3 | Not-allowed flags: run, wakeup, sleep |

## Verification
The flag logic is where two functions meet in one cycle: a rejected request can try to set a flag on the same clock that software writes 1 to clear it. The bench drives a disallowed sleep request together with a clear of the sleep flag. The flag must read set afterwards, and a later clear on its own must empty it. Done and a fresh request are also driven in the same busy cycle, and the request must leave target and start untouched.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
  typedef enum logic [1:0] {
    KIND_RUN   = 2'd0,
    KIND_SLEEP = 2'd1,
    KIND_WAKE  = 2'd2,
    KIND_NONE  = 2'd3
  } req_kind_e;

  localparam int FLAG_RUN   = 0;
  localparam int FLAG_WAKE  = 1;
  localparam int FLAG_SLEEP = 2;
  localparam int NUM_FLAGS  = 3;
endpackage

// File: rtl/sp_wake_store.sv
module sp_wake_store #(
  parameter int SP_W     = 4,
  parameter int RESET_SP = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_i,
  input  logic            sel_i,
  input  logic [SP_W-1:0] wake_sp_i,
  input  logic [SP_W-1:0] cur_sp_i,
  output logic [SP_W-1:0] wake_tgt_o
);
  logic [SP_W-1:0] wake_q, wake_d;
  logic            wake_en;

  always_comb begin
    wake_en = capture_i;
    wake_d  = sel_i ? cur_sp_i : wake_sp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_q <= SP_W'(RESET_SP);
    else if (wake_en) wake_q <= wake_d;
  end

  assign wake_tgt_o = wake_q;
endmodule

// File: rtl/sp_cand_filter.sv
module sp_cand_filter
  import sp_arb_pkg::*;
#(
  parameter int NUM_SP    = 16,
  parameter int SP_W      = 4,
  parameter int NUM_MODES = 4,
  parameter int MODE_W    = 2,
  parameter int NUM_REQ   = 2
) (
  input  logic                        idle_i,
  input  logic [NUM_REQ-1:0]          req_valid_i,
  input  logic [NUM_REQ*2-1:0]        req_kind_i,
  input  logic [NUM_REQ*SP_W-1:0]     req_tgt_i,
  input  logic [NUM_REQ*MODE_W-1:0]   req_mode_i,
  input  logic [NUM_SP*NUM_SP-1:0]    allow_map_i,
  input  logic [NUM_MODES*NUM_SP-1:0] mode_map_i,
  input  logic [SP_W-1:0]             cur_i,
  output logic [NUM_REQ-1:0]          live_o,
  output logic [NUM_SP-1:0]           cand_o,
  output logic [NUM_FLAGS-1:0]        kinds_o
);
  logic [NUM_SP-1:0]    onehot  [NUM_REQ];
  logic [NUM_SP-1:0]    mmask   [NUM_REQ];
  logic [NUM_FLAGS-1:0] kind_oh [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    logic [1:0]        kind_g;
    logic [SP_W-1:0]   tgt_g;
    logic [MODE_W-1:0] mode_g;
    assign kind_g    = req_kind_i[g*2 +: 2];
    assign tgt_g     = req_tgt_i[g*SP_W +: SP_W];
    assign mode_g    = req_mode_i[g*MODE_W +: MODE_W];
    assign live_o[g] = idle_i && req_valid_i[g] && (kind_g != KIND_NONE);
    assign onehot[g] = live_o[g] ? (NUM_SP'(1) << tgt_g) : '0;
    assign mmask[g]  = live_o[g] ? mode_map_i[mode_g*NUM_SP +: NUM_SP] : '1;
    always_comb begin
      kind_oh[g]             = '0;
      kind_oh[g][FLAG_RUN]   = live_o[g] && (kind_g == KIND_RUN);
      kind_oh[g][FLAG_WAKE]  = live_o[g] && (kind_g == KIND_WAKE);
      kind_oh[g][FLAG_SLEEP] = live_o[g] && (kind_g == KIND_SLEEP);
    end
  end

  logic [NUM_SP-1:0] req_bits, mode_and, row_bits;

  always_comb begin
    req_bits = '0;
    mode_and = '1;
    kinds_o  = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      req_bits = req_bits | onehot[r];
      mode_and = mode_and & mmask[r];
      kinds_o  = kinds_o | kind_oh[r];
    end
    row_bits = allow_map_i[cur_i*NUM_SP +: NUM_SP];
    cand_o   = req_bits & row_bits & mode_and;
  end
endmodule

// File: rtl/sp_prio_pick.sv
module sp_prio_pick #(
  parameter int NUM_SP = 16,
  parameter int SP_W   = 4,
  parameter int PRIO_W = 4,
  localparam int HALF  = NUM_SP / 2
) (
  input  logic [NUM_SP-1:0]      cand_i,
  input  logic [HALF*PRIO_W-1:0] prio_lo_i,
  input  logic [HALF*PRIO_W-1:0] prio_hi_i,
  output logic                   any_o,
  output logic [SP_W-1:0]        pick_o
);
  logic [PRIO_W-1:0] pri [NUM_SP];

  for (genvar g = 0; g < NUM_SP; g++) begin : g_pri
    if (g < HALF) begin : g_lo
      assign pri[g] = prio_lo_i[g*PRIO_W +: PRIO_W];
    end else begin : g_hi
      assign pri[g] = prio_hi_i[(g-HALF)*PRIO_W +: PRIO_W];
    end
  end

  logic [PRIO_W-1:0] best_pri;

  always_comb begin
    any_o    = 1'b0;
    pick_o   = '0;
    best_pri = '0;
    for (int i = 0; i < NUM_SP; i++) begin
      // strict compare keeps the lower index on equal priority
      if (cand_i[i] && (!any_o || (pri[i] > best_pri))) begin
        any_o    = 1'b1;
        pick_o   = SP_W'(i);
        best_pri = pri[i];
      end
    end
  end
endmodule

// File: rtl/setpoint_arbiter.sv
module setpoint_arbiter
  import sp_arb_pkg::*;
#(
  parameter int NUM_SP    = 16,
  parameter int NUM_MODES = 4,
  parameter int PRIO_W    = 4,
  parameter int NUM_REQ   = 2,
  parameter int RESET_SP  = 0,
  localparam int SP_W     = $clog2(NUM_SP),
  localparam int MODE_W   = $clog2(NUM_MODES),
  localparam int HALF     = NUM_SP / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SP*NUM_SP-1:0]    allow_map_i,
  input  logic [NUM_MODES*NUM_SP-1:0] mode_map_i,
  input  logic [HALF*PRIO_W-1:0]      prio_lo_i,
  input  logic [HALF*PRIO_W-1:0]      prio_hi_i,
  input  logic [NUM_REQ-1:0]          req_valid_i,
  input  logic [NUM_REQ*2-1:0]        req_kind_i,
  input  logic [NUM_REQ*SP_W-1:0]     req_sp_i,
  input  logic [NUM_REQ*SP_W-1:0]     req_wake_sp_i,
  input  logic [NUM_REQ-1:0]          req_wake_sel_i,
  input  logic [NUM_REQ*MODE_W-1:0]   req_mode_i,
  input  logic                        done_i,
  input  logic [NUM_FLAGS-1:0]        flag_clr_i,
  output logic [SP_W-1:0]             target_o,
  output logic [SP_W-1:0]             current_o,
  output logic [SP_W-1:0]             previous_o,
  output logic                        busy_o,
  output logic                        start_o,
  output logic [NUM_FLAGS-1:0]        flags_o
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  logic [SP_W-1:0]      cur_q, prev_q, tgt_q;
  logic [SP_W-1:0]      cur_d, prev_d, tgt_d;
  logic                 busy_q, busy_d, start_q, start_d;
  logic [NUM_FLAGS-1:0] flag_q, flag_d;
  logic                 tgt_en, stat_en;

  // per-requester target resolution and wakeup memory
  logic [NUM_REQ*SP_W-1:0] req_tgt;
  logic [NUM_REQ-1:0]      live;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_wake
    logic [SP_W-1:0] stored_sp;
    logic            cap;
    assign cap = live[g] && (req_kind_i[g*2 +: 2] == KIND_SLEEP);

    sp_wake_store #(
      .SP_W     (SP_W),
      .RESET_SP (RESET_SP)
    ) u_store (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .capture_i  (cap),
      .sel_i      (req_wake_sel_i[g]),
      .wake_sp_i  (req_wake_sp_i[g*SP_W +: SP_W]),
      .cur_sp_i   (cur_q),
      .wake_tgt_o (stored_sp)
    );

    assign req_tgt[g*SP_W +: SP_W] = (req_kind_i[g*2 +: 2] == KIND_WAKE)
                                     ? stored_sp : req_sp_i[g*SP_W +: SP_W];
  end

  logic [NUM_SP-1:0]    cand;
  logic [NUM_FLAGS-1:0] kinds;
  logic                 any_cand;
  logic [SP_W-1:0]      pick;

  sp_cand_filter #(
    .NUM_SP    (NUM_SP),
    .SP_W      (SP_W),
    .NUM_MODES (NUM_MODES),
    .MODE_W    (MODE_W),
    .NUM_REQ   (NUM_REQ)
  ) u_filter (
    .idle_i      (!busy_q),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_tgt_i   (req_tgt),
    .req_mode_i  (req_mode_i),
    .allow_map_i (allow_map_i),
    .mode_map_i  (mode_map_i),
    .cur_i       (cur_q),
    .live_o      (live),
    .cand_o      (cand),
    .kinds_o     (kinds)
  );

  sp_prio_pick #(
    .NUM_SP (NUM_SP),
    .SP_W   (SP_W),
    .PRIO_W (PRIO_W)
  ) u_pick (
    .cand_i    (cand),
    .prio_lo_i (prio_lo_i),
    .prio_hi_i (prio_hi_i),
    .any_o     (any_cand),
    .pick_o    (pick)
  );

  // next state
  logic accept, reject;

  always_comb begin
    accept  = !busy_q && any_cand;
    reject  = !busy_q && (|live) && !any_cand;
    tgt_en  = accept;
    stat_en = busy_q && done_i;
    tgt_d   = pick;
    cur_d   = tgt_q;
    prev_d  = cur_q;
    start_d = accept;
    busy_d  = busy_q;
    if (accept)  busy_d = 1'b1;
    if (stat_en) busy_d = 1'b0;
    flag_d  = (flag_q & ~flag_clr_i) | (reject ? kinds : '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tgt_q <= SP_W'(RESET_SP);
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_q  <= SP_W'(RESET_SP);
      prev_q <= SP_W'(RESET_SP);
    end else if (stat_en) begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      flag_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      flag_q  <= flag_d;
    end
  end

  assign target_o   = tgt_q;
  assign current_o  = cur_q;
  assign previous_o = prev_q;
  assign busy_o     = busy_q;
  assign start_o    = start_q;
  assign flags_o    = flag_q;
endmodule

// File: rtl/sp_arb_checker.sv
module sp_arb_checker #(
  parameter int SP_W   = 4,
  parameter int NFLAGS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_o,
  input logic              busy_o,
  input logic              done_i,
  input logic [SP_W-1:0]   target_o,
  input logic [SP_W-1:0]   current_o,
  input logic [SP_W-1:0]   previous_o,
  input logic [NFLAGS-1:0] flags_o,
  input logic [NFLAGS-1:0] flag_clr_i
);
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);

  assert_done_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i) |=> (!busy_o && current_o == $past(target_o)
                            && previous_o == $past(current_o)));

  assert_idle_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && done_i) |=> ($stable(current_o) && $stable(previous_o)));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> (busy_o && !start_o && $stable(target_o)));

  for (genvar b = 0; b < NFLAGS; b++) begin : g_flag
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[b] && !flag_clr_i[b]) |=> flags_o[b]);

    assert_flag_nostart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[b]) |-> !start_o);
  end
endmodule

bind setpoint_arbiter sp_arb_checker #(
  .SP_W   (SP_W),
  .NFLAGS (sp_arb_pkg::NUM_FLAGS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_o    (start_o),
  .busy_o     (busy_o),
  .done_i     (done_i),
  .target_o   (target_o),
  .current_o  (current_o),
  .previous_o (previous_o),
  .flags_o    (flags_o),
  .flag_clr_i (flag_clr_i)
);

// File: tb/sim_setpoint_arbiter.sv
module sim_setpoint_arbiter;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] allow_map;
  logic [63:0]  mode_map;
  logic [31:0]  prio_lo, prio_hi;
  logic [1:0]   req_valid;
  logic [3:0]   req_kind;
  logic [7:0]   req_sp, req_wsp;
  logic [1:0]   req_wsel;
  logic [3:0]   req_mode;
  logic         done;
  logic [2:0]   clr;
  logic [3:0]   target, current, previous;
  logic         busy, start;
  logic [2:0]   flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  setpoint_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .allow_map_i(allow_map), .mode_map_i(mode_map),
    .prio_lo_i(prio_lo), .prio_hi_i(prio_hi), .req_valid_i(req_valid),
    .req_kind_i(req_kind), .req_sp_i(req_sp), .req_wake_sp_i(req_wsp),
    .req_wake_sel_i(req_wsel), .req_mode_i(req_mode), .done_i(done),
    .flag_clr_i(clr), .target_o(target), .current_o(current),
    .previous_o(previous), .busy_o(busy), .start_o(start), .flags_o(flags)
  );

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic set_req(int r, logic [1:0] k, int sp, int wsp, bit wsel, int md);
    req_valid[r]      = 1'b1;
    req_kind[r*2+:2]  = k;
    req_sp[r*4+:4]    = 4'(sp);
    req_wsp[r*4+:4]   = 4'(wsp);
    req_wsel[r]       = wsel;
    req_mode[r*2+:2]  = 2'(md);
  endtask

  task automatic set_prio(int n, int p);
    if (n < 8) prio_lo[4*n +: 4] = 4'(p);
    else       prio_hi[4*(n-8) +: 4] = 4'(p);
  endtask

  // requests already set; steps one clock and checks acceptance
  task automatic issue(string rq, int exp_tgt);
    @(negedge clk);
    req_valid = '0;
    chk({rq, " start"}, int'(start), 1);
    chk({rq, " target"}, int'(target), exp_tgt);
    chk({rq, " busy"}, int'(busy), 1);
    @(negedge clk);
    chk("R5 start one cycle", int'(start), 0);
  endtask

  task automatic finish_tr(int exp_cur, int exp_prev);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R6 current", int'(current), exp_cur);
    chk("R6 previous", int'(previous), exp_prev);
    chk("R6 busy clear", int'(busy), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 current", int'(current), 0);
    chk("R1 previous", int'(previous), 0);
    chk("R1 target", int'(target), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 start", int'(start), 0);
    chk("R1 flags", int'(flags), 0);
  endtask

  task automatic t_single();
    set_req(0, 2'd0, 5, 0, 0, 0);
    issue("R5 single", 5);
    finish_tr(5, 0);
    done = 1'b1;              // done while idle: R6 no effect
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    chk("R6 idle done current", int'(current), 5);
    chk("R6 idle done previous", int'(previous), 0);
  endtask

  task automatic t_priority();
    set_prio(9, 7);
    set_prio(3, 2);
    set_req(0, 2'd0, 3, 0, 0, 0);
    set_req(1, 2'd0, 9, 0, 0, 0);
    issue("R3 priority", 9);
    finish_tr(9, 5);
  endtask

  task automatic t_tie();
    prio_lo = '0;
    prio_hi = '0;
    set_req(0, 2'd0, 12, 0, 0, 0);
    set_req(1, 2'd0, 2, 0, 0, 0);
    issue("R4 tie", 2);
    finish_tr(2, 9);
  endtask

  task automatic t_filter();
    allow_map[2*16 + 6] = 1'b0;   // row of setpoint 2 forbids 6
    set_prio(6, 15);
    set_req(0, 2'd0, 6, 0, 0, 0);
    set_req(1, 2'd0, 4, 0, 0, 0);
    issue("R2 allow row", 4);
    finish_tr(4, 2);
    allow_map = '1;
    mode_map[2*16 + 7] = 1'b0;    // stop mode forbids 7
    set_prio(7, 15);
    set_req(0, 2'd0, 7, 0, 0, 0);
    set_req(1, 2'd0, 1, 0, 0, 2);
    issue("R2 mode map", 1);
    finish_tr(1, 4);
    mode_map = '1;
  endtask

  task automatic t_reject();
    allow_map[16 +: 16] = 16'h0002;  // from 1 only 1 is allowed
    set_req(0, 2'd0, 3, 0, 0, 0);
    @(negedge clk);
    req_valid = '0;
    chk("R8 no start", int'(start), 0);
    chk("R8 run flag", int'(flags), 1);
    chk("R8 still idle", int'(busy), 0);
    set_req(0, 2'd1, 3, 0, 0, 2);
    @(negedge clk);
    req_valid = '0;
    chk("R8 sleep flag", int'(flags), 5);
    clr = 3'b001;
    @(negedge clk);
    clr = 3'b000;
    chk("R9 clear run", int'(flags), 4);
    clr = 3'b100;                    // clear and set in one cycle
    set_req(0, 2'd1, 3, 0, 0, 2);
    @(negedge clk);
    req_valid = '0;
    clr = 3'b000;
    chk("R9 set beats clear", int'(flags), 4);
    clr = 3'b100;
    @(negedge clk);
    clr = 3'b000;
    chk("R9 clear sleep", int'(flags), 0);
    allow_map = '1;
  endtask

  task automatic t_busy_ignore();
    set_req(0, 2'd0, 8, 0, 0, 0);
    issue("R5 busy start", 8);
    set_prio(13, 15);
    set_req(1, 2'd0, 13, 0, 0, 0);
    done = 1'b1;                     // done and new request same cycle
    @(negedge clk);
    done = 1'b0;
    req_valid = '0;
    chk("R7 target kept", int'(target), 8);
    chk("R7 no start", int'(start), 0);
    chk("R6 commit", int'(current), 8);
    set_req(0, 2'd3, 13, 0, 0, 0);   // kind 3
    @(negedge clk);
    req_valid = '0;
    chk("R7 kind3 no start", int'(start), 0);
    chk("R7 kind3 idle", int'(busy), 0);
    chk("R7 kind3 target", int'(target), 8);
  endtask

  task automatic t_wake();
    set_req(0, 2'd1, 10, 11, 0, 2);
    issue("R10 sleep sel0", 10);
    finish_tr(10, 8);
    set_req(0, 2'd2, 0, 0, 0, 0);
    issue("R10 wake programmed", 11);
    finish_tr(11, 10);
    set_req(0, 2'd1, 0, 5, 1, 3);
    issue("R10 sleep sel1", 0);
    finish_tr(0, 11);
    set_req(0, 2'd2, 4, 0, 0, 0);
    issue("R10 wake to previous", 11);
    finish_tr(11, 0);
  endtask

  initial begin
    allow_map = '1;
    mode_map  = '1;
    prio_lo   = '0;
    prio_hi   = '0;
    req_valid = '0;
    req_kind  = '0;
    req_sp    = '0;
    req_wsp   = '0;
    req_wsel  = '0;
    req_mode  = '0;
    done      = 1'b0;
    clr       = '0;
    rst_n     = 1'b0;
    t_reset();
    t_single();
    t_priority();
    t_tie();
    t_filter();
    t_reject();
    t_busy_ignore();
    t_wake();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule